// File: doc/BRIEF.md
# Configurable-Write-Mode Synchronous Block RAM

This block is a single-port memory with a registered read path, shaped after the dedicated RAM tiles found in programmable logic. A port enable gates every access. A write enable stores a data word together with a parity lane. A synchronous output reset loads the read register with a constant. One parameter selects what the read register shows when a write happens: the word that was there before, the word being written, or its own previous value.

The array always holds 16,384 data bits. The data width picks the depth: 16K×1, 8K×2 or 4K×4 with no parity, or 2K×(8+1), 1K×(16+2) or 512×(32+4) with one parity bit per byte. Power-on contents come from two flat parameter vectors. One holds 16,384 data bits and the other 2,048 parity bits, and word k sits at bit offset k times its width, so address 0 is at the least significant end. Two more parameters give the read register's value after the asynchronous reset and after the synchronous output reset.

Top module: `bram_sp_mem`

## Requirements
- R1: With `en_i`=1, `we_i`=0 and `srst_i`=0, a rising edge loads `rdata_o`/`rpar_o` with the word stored at `addr_i`. The outputs change only at rising edges, so a read shows a word written in any earlier cycle.
- R2: With `en_i`=0 a rising edge neither stores anything nor changes the outputs, whatever `we_i`, `srst_i` or `addr_i` are.
- R3: With `WMODE`=`WM_READ_FIRST`, a write cycle (`en_i`=1, `we_i`=1, `srst_i`=0) loads the outputs with the previous contents of the addressed word and stores the new word in the same edge.
- R4: With `WMODE`=`WM_WRITE_FIRST`, a write cycle loads the outputs with `wdata_i`/`wpar_i` as they are written.
- R5: With `WMODE`=`WM_NO_CHANGE`, a write cycle stores the word and leaves the outputs at their previous value.
- R6: When `srst_i`=1 and `en_i`=1, the next edge loads `{rdata_o,rpar_o}` with `SRST_OUT` in every mode. If `we_i`=1 in that cycle, the write is still performed.
- R7: While `rst_ni`=0, `{rdata_o,rpar_o}` equals `INIT_OUT` at once, without a clock edge. The array contents are not changed.
- R8: After power-on, data word k equals `INIT_DATA[k*DATA_W +: DATA_W]` and parity word k equals `INIT_PAR[k*PAR_W +: PAR_W]`.
- R9: Depth is 16384/`DATA_W`. For `DATA_W` of 8, 16 or 32 the parity lane is `DATA_W`/8 bits wide. For `DATA_W` of 1, 2 or 4 the lane is a single bit: it stores nothing, ignores `wpar_i` and always reads 0.
- R10: The parity lane is written, read and reset together with its data word in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the read register to `INIT_OUT` |
| en_i | input | 1 | Port enable |
| we_i | input | 1 | Write enable |
| srst_i | input | 1 | Synchronous output reset to `SRST_OUT` |
| addr_i | input | ADDR_W | Word address, ADDR_W = log2(16384/DATA_W) |
| wdata_i | input | DATA_W | Write data |
| wpar_i | input | LANE_W | Write parity |
| rdata_o | output | DATA_W | Registered read data |
| rpar_o | output | LANE_W | Registered read parity |

## Verification
Every read, write-mode result and output reset takes effect at the first rising edge after its inputs are presented. Only the asynchronous reset acts without waiting for an edge. The bench drives each set of inputs at a falling edge and updates its own model at the next rising edge. It then compares the outputs of one instance per write mode, and of a narrow 4K×4 instance, at the falling edge that follows. For the asynchronous reset it compares one time unit after `rst_ni` falls, before any edge.

// File: rtl/bram_pkg.sv
package bram_pkg;
  localparam int TOTAL_DATA_BITS = 16384;
  localparam int TOTAL_PAR_BITS  = 2048;

  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  function automatic int par_w(input int dw);
    return (dw >= 8) ? dw / 8 : 0;
  endfunction

  function automatic int lane_w(input int dw);
    return (dw >= 8) ? dw / 8 : 1;
  endfunction
endpackage

// File: rtl/bram_store.sv
module bram_store #(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 4,
  parameter int LANE_W = 4,
  parameter int ADDR_W = 9,
  parameter logic [bram_pkg::TOTAL_DATA_BITS-1:0] INIT_DATA = '0,
  parameter logic [bram_pkg::TOTAL_PAR_BITS-1:0]  INIT_PAR  = '0
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [LANE_W-1:0] wp_i,
  output logic [DATA_W-1:0] rd_o,
  output logic [LANE_W-1:0] rp_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] dmem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) dmem[i] = INIT_DATA[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) dmem[addr_i] <= wd_i;
  end

  // old word, captured or bypassed by the output stage
  assign rd_o = dmem[addr_i];

  if (PAR_W > 0) begin : g_par
    logic [PAR_W-1:0] pmem [DEPTH];

    initial begin
      for (int i = 0; i < DEPTH; i++) pmem[i] = INIT_PAR[i*PAR_W +: PAR_W];
    end

    always_ff @(posedge clk_i) begin
      if (wr_i) pmem[addr_i] <= wp_i;
    end

    assign rp_o = pmem[addr_i];
  end else begin : g_nopar
    logic unused_par;
    assign unused_par = ^{wp_i, INIT_PAR};
    assign rp_o = '0;
  end
endmodule

// File: rtl/bram_outreg.sv
module bram_outreg #(
  parameter int OUT_W = 36,
  parameter bram_pkg::wmode_e WMODE = bram_pkg::WM_READ_FIRST,
  parameter logic [OUT_W-1:0] INIT_OUT = '0,
  parameter logic [OUT_W-1:0] SRST_OUT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic             srst_i,
  input  logic [OUT_W-1:0] old_i,
  input  logic [OUT_W-1:0] new_i,
  output logic [OUT_W-1:0] q_o
);
  logic [OUT_W-1:0] wr_val, q_nxt;

  if (WMODE == bram_pkg::WM_WRITE_FIRST) begin : g_wf
    assign wr_val = new_i;
  end else if (WMODE == bram_pkg::WM_NO_CHANGE) begin : g_nc
    logic unused_old;
    assign unused_old = ^new_i;
    assign wr_val = q_o;
  end else begin : g_rf
    logic unused_new;
    assign unused_new = ^new_i;
    assign wr_val = old_i;
  end

  always_comb begin
    q_nxt = q_o;
    if (en_i) begin
      if (srst_i)     q_nxt = SRST_OUT;
      else if (we_i)  q_nxt = wr_val;
      else            q_nxt = old_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= INIT_OUT;
    else         q_o <= q_nxt;
  end
endmodule

// File: rtl/bram_sp_mem.sv
module bram_sp_mem #(
  parameter int DATA_W = 32,
  parameter bram_pkg::wmode_e WMODE = bram_pkg::WM_READ_FIRST,
  localparam int PAR_W  = bram_pkg::par_w(DATA_W),
  localparam int LANE_W = bram_pkg::lane_w(DATA_W),
  localparam int ADDR_W = $clog2(bram_pkg::TOTAL_DATA_BITS / DATA_W),
  localparam int OUT_W  = DATA_W + LANE_W,
  parameter logic [OUT_W-1:0] INIT_OUT = '0,
  parameter logic [OUT_W-1:0] SRST_OUT = '0,
  parameter logic [bram_pkg::TOTAL_DATA_BITS-1:0] INIT_DATA = '0,
  parameter logic [bram_pkg::TOTAL_PAR_BITS-1:0]  INIT_PAR  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic              srst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANE_W-1:0] wpar_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANE_W-1:0] rpar_o
);
  logic              wr;
  logic [DATA_W-1:0] old_d;
  logic [LANE_W-1:0] old_p, new_p;
  logic [OUT_W-1:0]  q;

  assign wr    = en_i & we_i;
  assign new_p = (PAR_W > 0) ? wpar_i : '0;

  bram_store #(
    .DATA_W(DATA_W), .PAR_W(PAR_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W),
    .INIT_DATA(INIT_DATA), .INIT_PAR(INIT_PAR)
  ) i_store (
    .clk_i(clk_i), .wr_i(wr), .addr_i(addr_i), .wd_i(wdata_i), .wp_i(wpar_i),
    .rd_o(old_d), .rp_o(old_p)
  );

  bram_outreg #(
    .OUT_W(OUT_W), .WMODE(WMODE), .INIT_OUT(INIT_OUT), .SRST_OUT(SRST_OUT)
  ) i_outreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .we_i(we_i), .srst_i(srst_i),
    .old_i({old_d, old_p}), .new_i({wdata_i, new_p}), .q_o(q)
  );

  assign rdata_o = q[OUT_W-1 -: DATA_W];
  assign rpar_o  = q[LANE_W-1:0];
endmodule

// File: rtl/bram_sp_mem_chk.sv
module bram_sp_mem_chk #(
  parameter int DATA_W = 32,
  parameter bram_pkg::wmode_e WMODE = bram_pkg::WM_READ_FIRST,
  parameter int LANE_W = 4,
  parameter int ADDR_W = 9,
  parameter logic [DATA_W+LANE_W-1:0] SRST_OUT = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              we_i,
  input logic              srst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [LANE_W-1:0] wpar_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [LANE_W-1:0] rpar_o
);
  logic unused_wp;
  assign unused_wp = ^wpar_i;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable({rdata_o, rpar_o}));

  // R6
  srst_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && srst_i |=> {rdata_o, rpar_o} == SRST_OUT);

  // R1
  raw_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && we_i) && en_i && !we_i && !srst_i && addr_i == $past(addr_i)
    |=> rdata_o == $past(wdata_i, 2));

  if (WMODE == bram_pkg::WM_READ_FIRST) begin : g_rf
    // R3
    rf_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(en_i && we_i) && en_i && we_i && !srst_i && addr_i == $past(addr_i)
      |=> rdata_o == $past(wdata_i, 2));
  end else if (WMODE == bram_pkg::WM_WRITE_FIRST) begin : g_wf
    // R4
    wf_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && we_i && !srst_i |=> rdata_o == $past(wdata_i));
  end else begin : g_nc
    // R5
    nc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && we_i && !srst_i |=> $stable({rdata_o, rpar_o}));
  end
endmodule

bind bram_sp_mem bram_sp_mem_chk #(
  .DATA_W(DATA_W), .WMODE(WMODE), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .SRST_OUT(SRST_OUT)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .we_i(we_i), .srst_i(srst_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .wpar_i(wpar_i), .rdata_o(rdata_o), .rpar_o(rpar_o)
);

// File: tb/test_bram_sp_mem.sv
module test_bram_sp_mem;
  import bram_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] W_INIT = 36'h1_2345_6789;
  localparam logic [35:0] W_SRST = 36'hF_DEAD_BEEF;
  localparam logic [4:0]  N_INIT = 5'b00000;
  localparam logic [4:0]  N_SRST = 5'b10100;

  function automatic logic [31:0] init_word(input int k);
    return (32'h9E37_79B9 * 32'(k + 1)) ^ 32'(k);
  endfunction
  function automatic logic [3:0] init_par(input int k);
    return 4'(k) ^ 4'hA;
  endfunction
  function automatic logic [TOTAL_DATA_BITS-1:0] mk_d();
    logic [TOTAL_DATA_BITS-1:0] v;
    for (int k = 0; k < 512; k++) v[k*32 +: 32] = init_word(k);
    return v;
  endfunction
  function automatic logic [TOTAL_PAR_BITS-1:0] mk_p();
    logic [TOTAL_PAR_BITS-1:0] v;
    for (int k = 0; k < 512; k++) v[k*4 +: 4] = init_par(k);
    return v;
  endfunction
  localparam logic [TOTAL_DATA_BITS-1:0] IDATA = mk_d();
  localparam logic [TOTAL_PAR_BITS-1:0]  IPAR  = mk_p();

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, we = 1'b0, srst = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wpar = '0;
  logic [31:0] rd_rf, rd_wf, rd_nc;
  logic [3:0]  rp_rf, rp_wf, rp_nc;
  logic [3:0]  rd_n;
  logic        rp_n;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bram_sp_mem #(.DATA_W(32), .WMODE(WM_READ_FIRST), .INIT_OUT(W_INIT), .SRST_OUT(W_SRST),
    .INIT_DATA(IDATA), .INIT_PAR(IPAR)) i_bram_sp_mem (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .we_i(we), .srst_i(srst), .addr_i(addr[8:0]),
    .wdata_i(wdata), .wpar_i(wpar), .rdata_o(rd_rf), .rpar_o(rp_rf));
  bram_sp_mem #(.DATA_W(32), .WMODE(WM_WRITE_FIRST), .INIT_OUT(W_INIT), .SRST_OUT(W_SRST),
    .INIT_DATA(IDATA), .INIT_PAR(IPAR)) i_bram_sp_mem_wf (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .we_i(we), .srst_i(srst), .addr_i(addr[8:0]),
    .wdata_i(wdata), .wpar_i(wpar), .rdata_o(rd_wf), .rpar_o(rp_wf));
  bram_sp_mem #(.DATA_W(32), .WMODE(WM_NO_CHANGE), .INIT_OUT(W_INIT), .SRST_OUT(W_SRST),
    .INIT_DATA(IDATA), .INIT_PAR(IPAR)) i_bram_sp_mem_nc (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .we_i(we), .srst_i(srst), .addr_i(addr[8:0]),
    .wdata_i(wdata), .wpar_i(wpar), .rdata_o(rd_nc), .rpar_o(rp_nc));
  bram_sp_mem #(.DATA_W(4), .WMODE(WM_READ_FIRST), .INIT_OUT(N_INIT), .SRST_OUT(N_SRST))
    i_bram_sp_mem_nar (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .we_i(we), .srst_i(srst), .addr_i(addr),
    .wdata_i(wdata[3:0]), .wpar_i(wpar[0]), .rdata_o(rd_n), .rpar_o(rp_n));

  // reference model
  logic [35:0] mem_m [512];
  logic [3:0]  nmem [4096];
  logic [35:0] q_rf, q_wf, q_nc;
  logic [4:0]  q_n;

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " rf"}, {rd_rf, rp_rf}, q_rf);
    chk({tag, " wf"}, {rd_wf, rp_wf}, q_wf);
    chk({tag, " nc"}, {rd_nc, rp_nc}, q_nc);
    chk({tag, " R9 narrow"}, {31'd0, rd_n, rp_n}, {31'd0, q_n});
  endtask

  task automatic cyc(input logic e, input logic w, input logic s, input logic [11:0] a,
                     input logic [31:0] d, input logic [3:0] p, input string tag);
    logic [35:0] old, nw;
    logic [3:0]  nold;
    en = e; we = w; srst = s; addr = a; wdata = d; wpar = p;
    @(posedge clk);
    old = mem_m[a[8:0]]; nw = {d, p}; nold = nmem[a];
    if (e) begin
      if (s) begin
        q_rf = W_SRST; q_wf = W_SRST; q_nc = W_SRST; q_n = N_SRST;
      end else if (!w) begin
        q_rf = old; q_wf = old; q_nc = old; q_n = {nold, 1'b0};
      end else begin
        q_rf = old; q_wf = nw; q_n = {nold, 1'b0};
      end
      if (w) begin
        mem_m[a[8:0]] = nw;
        nmem[a] = d[3:0];
      end
    end
    @(negedge clk);
    en = 1'b0; we = 1'b0; srst = 1'b0;
    chk_all(tag);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 512; k++) mem_m[k] = {init_word(k), init_par(k)};
    for (int k = 0; k < 4096; k++) nmem[k] = '0;
    q_rf = W_INIT; q_wf = W_INIT; q_nc = W_INIT; q_n = N_INIT;
    @(negedge clk); @(negedge clk);
    chk_all("R7 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R7 after release");
  endtask

  task automatic t_init_read();
    cyc(1, 0, 0, 12'd0,   '0, '0, "R8 R1 init addr0");
    cyc(1, 0, 0, 12'd1,   '0, '0, "R8 R1 init addr1");
    cyc(1, 0, 0, 12'd511, '0, '0, "R8 R1 init top");
    cyc(1, 0, 0, 12'd200, '0, '0, "R8 R1 init mid");
  endtask

  task automatic t_enable_off();
    cyc(0, 1, 1, 12'd5, 32'hAAAA_5555, 4'h3, "R2 disabled write+srst");
    cyc(0, 0, 0, 12'd7, '0, '0, "R2 disabled read");
    cyc(1, 0, 0, 12'd5, '0, '0, "R2 word untouched");
  endtask

  task automatic t_write_modes();
    cyc(1, 1, 0, 12'd10, 32'hCAFE_0010, 4'h6, "R3 R4 R5 R10 write");
    cyc(1, 0, 0, 12'd10, '0, '0, "R1 R10 readback");
    cyc(1, 1, 0, 12'd10, 32'h1234_ABCD, 4'h9, "R3 R4 R5 rewrite");
    cyc(1, 1, 0, 12'd10, 32'h0BAD_F00D, 4'h1, "R3 R4 R5 back-to-back");
    cyc(1, 1, 0, 12'd11, 32'h7777_1111, 4'hE, "R3 R4 R5 other addr");
    cyc(1, 0, 0, 12'd10, '0, '0, "R1 R10 readback2");
  endtask

  task automatic t_srst();
    cyc(1, 1, 1, 12'd20, 32'h5A5A_A5A5, 4'hC, "R6 srst during write");
    cyc(1, 0, 0, 12'd20, '0, '0, "R6 write kept");
    cyc(1, 0, 1, 12'd21, '0, '0, "R6 srst during read");
  endtask

  task automatic t_async_reset();
    cyc(1, 0, 0, 12'd3, '0, '0, "R1 pre reset");
    #1 rst_ni = 1'b0;
    #1;
    q_rf = W_INIT; q_wf = W_INIT; q_nc = W_INIT; q_n = N_INIT;
    chk_all("R7 async");
    rst_ni = 1'b1;
    @(negedge clk);
    cyc(1, 0, 0, 12'd10, '0, '0, "R7 contents kept");
  endtask

  task automatic t_narrow();
    cyc(1, 1, 0, 12'd4095, 32'h0000_000B, 4'hF, "R9 deep write");
    cyc(1, 0, 0, 12'd4095, '0, '0, "R9 deep read");
    cyc(1, 0, 0, 12'd511, '0, '0, "R9 alias check");
  endtask

  task automatic t_sweep();
    logic [31:0] x = 32'h1357_9BDF;
    for (int i = 0; i < 80; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      cyc(x[0] | x[1], x[2], x[3] & x[4] & x[5], {8'd0, x[11:8]}, x ^ 32'hF0F0_0F0F,
          x[15:12], "R1 R2 R3 R4 R5 R6 sweep");
    end
  endtask

  initial begin
    t_reset();
    t_init_read();
    t_enable_off();
    t_write_modes();
    t_srst();
    t_async_reset();
    t_narrow();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule